// File: doc/BRIEF.md
# Frame-Synchronized Settings Shadow with Bad-Frame Masking

This block sits between a register write port and an image timing generator. Every image-control setting has two copies. Software writes into a pending copy. The timing logic reads only an active copy, and the active copy takes the pending values at a frame boundary. A frame boundary is the `frame_start` strobe. A hold bit in a small control register stops these transfers. The settings stay frozen until the bit is cleared, and the following boundary then applies everything written in the meantime.

Some settings change the geometry of the readout: horizontal blanking, window size, window position, skip/mirror and pixel-clock/zoom. When a boundary transfers a geometry setting whose pending value differs from its active value, the frame that starts there is corrupted. The block marks that frame as bad. By default it masks the frame, so the frame-valid and line-valid outputs stay low for the whole frame. A show-bad control bit lets every frame through. A restart-on-bad bit makes the block send a one-cycle restart request to the timing generator at the start of a bad frame.

The frame-valid and line-valid outputs come out one clock after the inputs.

Top module: `fsync_shadow_top`

## Requirements
- R1: After reset, every active setting is 0, the three control bits are 0, and `fv_out`, `lv_out` and `restart_req` are 0.
- R2: A write to a setting (addresses 0 to 8) changes the pending copy only. Its active copy on `act_bus` (setting i at bits [16*i+15:16*i]) changes in the first cycle after a `frame_start` strobe, and at no other time.
- R3: While the hold bit (control address 9, bit 0) is 1, `frame_start` transfers nothing and marks no frame bad. The first `frame_start` after the bit returns to 0 transfers the latest pending values.
- R4: A frame is bad when its `frame_start` transfers a geometry setting (address 2, 4, 5, 6 or 7) whose pending value differs from its active value.
- R5: Changes to integration time (0), gain (1), vertical blanking (3) or extra delay (8) never make a frame bad.
- R6: Writing a geometry setting with the value it already holds does not make the next frame bad.
- R7: With show-bad (address 9, bit 1) at 0, `fv_out` and `lv_out` stay low throughout a bad frame. In a good frame, they repeat `fv_in` and `lv_in` one cycle later.
- R8: With show-bad at 1, a bad frame reaches `fv_out` and `lv_out` like a good one.
- R9: With restart-on-bad (address 9, bit 2) at 1, `restart_req` is a single-cycle pulse in the cycle after the `frame_start` of a bad frame. It stays 0 for good frames and whenever the bit is 0.
- R10: The extra-delay setting (address 8) holds 14 bits. Bits 15:14 of a write to it are dropped.
- R11: A write to an address above 9 changes no setting and no control bit.
- R12: Badness lasts one frame. A later `frame_start` with no geometry difference gives a good frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: 0-8 settings, 9 control |
| wr_data | input | 16 | Write data |
| frame_start | input | 1 | One-cycle frame boundary strobe |
| fv_in | input | 1 | Frame valid from timing generator |
| lv_in | input | 1 | Line valid from timing generator |
| act_bus | output | 144 | Active settings, 16 bits per setting, setting i at bits [16*i+15:16*i] |
| fv_out | output | 1 | Gated frame valid, one cycle after input |
| lv_out | output | 1 | Gated line valid, one cycle after input |
| restart_req | output | 1 | Forced frame restart pulse |

## Verification
The main stimulus is a sequence of writes, one per frame, to each setting in turn. It mixes three cases: geometry changes, non-geometry changes, and geometry writes that repeat the current value. Each frame's valid counts and restart pulses show whether the block correctly separates real geometry changes from harmless ones. The same frames compare the active copy before and after the boundary, which shows that nothing moves before the strobe. Directed runs with the hold bit set and then cleared check that writes made during the hold take effect together at the first boundary after release. With show-bad set, the same change must pass through without masking. A write to an unmapped address and the 14-bit extra-delay field cover the cases where write data must be ignored or cut down.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  localparam int SET_W     = 16;
  localparam int NUM_SET   = 9;
  localparam int ADDR_W    = 4;
  localparam int CTRL_ADDR = 9;
  localparam int XDLY_IDX  = 8;
  localparam int XDLY_W    = 14;

  // control bit positions inside the control word
  localparam int CB_HOLD    = 0;
  localparam int CB_SHOWBAD = 1;
  localparam int CB_RESTART = 2;
  localparam int CTRL_W     = 3;

  // settings whose change corrupts the next frame's readout geometry
  function automatic logic is_geom(int idx);
    return (idx == 2) || (idx == 4) || (idx == 5) || (idx == 6) || (idx == 7);
  endfunction

  // storage width of each setting, as a bit mask
  function automatic logic [31:0] width_mask(int idx);
    if (idx == XDLY_IDX) return (32'h1 << XDLY_W) - 32'h1;
    return 32'hFFFF_FFFF;
  endfunction
endpackage

// File: rtl/shadow_bank.sv
module shadow_bank
  import fsync_pkg::*;
#(
  parameter int DATA_W = SET_W,
  parameter int NSET   = NUM_SET,
  parameter int AW     = ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   xfer,
  output logic [NSET*DATA_W-1:0] act_bus,
  output logic                   geom_diff
);
  localparam int BUS_W = NSET * DATA_W;

  logic [NSET-1:0] diff_vec;

  for (genvar gi = 0; gi < NSET; gi++) begin : g_set
    localparam logic [DATA_W-1:0] MASK = DATA_W'(width_mask(gi));
    localparam logic              GEOM = is_geom(gi);

    logic              we;
    logic [DATA_W-1:0] pend_d, pend_q;
    logic [DATA_W-1:0] act_d, act_q;

    // next-state
    always_comb begin
      we     = wr_en && (wr_addr == AW'(gi));
      pend_d = we   ? (wr_data & MASK) : pend_q;
      act_d  = xfer ? pend_q           : act_q;
    end

    // registers
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= '0;
        act_q  <= '0;
      end else begin
        if (we)   pend_q <= pend_d;
        if (xfer) act_q  <= act_d;
      end
    end

    assign diff_vec[gi]                  = GEOM && (pend_q != act_q);
    assign act_bus[gi*DATA_W +: DATA_W]  = act_q;
  end

  assign geom_diff = |diff_vec;

  // R2: the active copy moves only in the cycle after a transfer strobe
  p_nocopy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(act_bus))
    else $error("active settings changed without a frame boundary");

  // R10: the extra-delay field never holds bits above its width
  p_xdly_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (act_bus[XDLY_IDX*DATA_W +: DATA_W] & ~DATA_W'(width_mask(XDLY_IDX))) == '0)
    else $error("extra delay holds bits beyond its width");

  logic unused_bw;
  assign unused_bw = (BUS_W == 0);
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import fsync_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int CADDR = CTRL_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CTRL_W-1:0] wr_ctrl,
  input  logic              frame_start,
  input  logic              geom_diff,
  output logic              xfer,
  output logic              mask_now,
  output logic              restart_req
);
  logic              ctrl_we;
  logic [CTRL_W-1:0] ctrl_d, ctrl_q;
  logic              bad_d, bad_q;
  logic              rst_d, rst_q;
  logic              new_bad;
  logic              hold, show_bad, restart_en;

  assign hold       = ctrl_q[CB_HOLD];
  assign show_bad   = ctrl_q[CB_SHOWBAD];
  assign restart_en = ctrl_q[CB_RESTART];

  // next-state
  always_comb begin
    ctrl_we  = wr_en && (wr_addr == AW'(CADDR));
    ctrl_d   = ctrl_we ? wr_ctrl : ctrl_q;
    xfer     = frame_start && !hold;
    new_bad  = xfer && geom_diff;
    bad_d    = frame_start ? new_bad : bad_q;
    rst_d    = new_bad && restart_en;
    mask_now = (frame_start ? new_bad : bad_q) && !show_bad;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      bad_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (ctrl_we)     ctrl_q <= ctrl_d;
      if (frame_start) bad_q  <= bad_d;
      rst_q <= rst_d;
    end
  end

  assign restart_req = rst_q;

  // R3: a held boundary never opens a bad frame
  p_hold_nobad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && hold) |=> !bad_q)
    else $error("bad frame flagged while hold was set");

  // R5/R6: a boundary without geometry difference opens a good frame
  p_nogeom_good_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !geom_diff) |=> !bad_q)
    else $error("frame flagged bad without geometry difference");

  // R9: a restart pulse always follows a boundary strobe
  p_restart_after_fs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> $past(frame_start))
    else $error("restart request without frame boundary");

  // R12: badness changes only at a boundary
  p_bad_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(bad_q))
    else $error("bad flag changed inside a frame");
endmodule

// File: rtl/valid_gate.sv
module valid_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_i,
  input  logic fv_i,
  input  logic lv_i,
  output logic fv_o,
  output logic lv_o
);
  logic fv_d, fv_q, lv_d, lv_q;

  // next-state
  always_comb begin
    fv_d = fv_i && !mask_i;
    lv_d = lv_i && !mask_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_q <= 1'b0;
      lv_q <= 1'b0;
    end else begin
      fv_q <= fv_d;
      lv_q <= lv_d;
    end
  end

  assign fv_o = fv_q;
  assign lv_o = lv_q;

  // R7: a masked cycle shows no valid one cycle later
  p_mask_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i |=> (!fv_o && !lv_o))
    else $error("valid leaked from masked frame");

  // R8: an unmasked frame valid always reaches the output
  p_pass_fv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_i && fv_i) |=> fv_o)
    else $error("unmasked frame valid dropped");
endmodule

// File: rtl/fsync_shadow_top.sv
module fsync_shadow_top
  import fsync_pkg::*;
#(
  parameter int DATA_W = SET_W,
  parameter int NSET   = NUM_SET,
  parameter int AW     = ADDR_W,
  parameter int CADDR  = CTRL_ADDR
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   frame_start,
  input  logic                   fv_in,
  input  logic                   lv_in,
  output logic [NSET*DATA_W-1:0] act_bus,
  output logic                   fv_out,
  output logic                   lv_out,
  output logic                   restart_req
);
  logic       rst_s1_q, rst_s2_q;
  logic       rst_ni;
  logic       xfer, geom_diff, mask_now;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_ni = rst_s2_q;

  shadow_bank #(.DATA_W(DATA_W), .NSET(NSET), .AW(AW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_ni),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .xfer      (xfer),
    .act_bus   (act_bus),
    .geom_diff (geom_diff)
  );

  frame_ctrl #(.AW(AW), .CADDR(CADDR)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_ni),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_ctrl     (wr_data[CTRL_W-1:0]),
    .frame_start (frame_start),
    .geom_diff   (geom_diff),
    .xfer        (xfer),
    .mask_now    (mask_now),
    .restart_req (restart_req)
  );

  valid_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_ni),
    .mask_i (mask_now),
    .fv_i   (fv_in),
    .lv_i   (lv_in),
    .fv_o   (fv_out),
    .lv_o   (lv_out)
  );

  // R1: outputs quiet while reset is applied
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_ni |=> (!restart_req || !rst_ni))
    else $error("restart during reset");
endmodule

// File: tb/sim_fsync_shadow_top.sv
module sim_fsync_shadow_top;
  localparam int DW = 16;
  localparam int NS = 9;
  localparam int AW = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en, frame_start, fv_in, lv_in;
  logic [AW-1:0]     wr_addr;
  logic [DW-1:0]     wr_data;
  logic [NS*DW-1:0]  act_bus;
  logic              fv_out, lv_out, restart_req;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] m_pend [NS];
  logic [DW-1:0] m_act  [NS];
  bit g_hold, g_show, g_rst;

  always #10 clk = ~clk;  // 50 MHz

  fsync_shadow_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_start(frame_start), .fv_in(fv_in), .lv_in(lv_in),
    .act_bus(act_bus), .fv_out(fv_out), .lv_out(lv_out), .restart_req(restart_req)
  );

  // vector: addr[38:35] data[34:19] exp_act[18:3] exp_bad[2] kind[1:0]
  localparam logic [38:0] VEC [10] = '{
    {4'd2, 16'h0010, 16'h0010, 1'b1, 2'd0},
    {4'd1, 16'h0033, 16'h0033, 1'b0, 2'd1},
    {4'd2, 16'h0010, 16'h0010, 1'b0, 2'd2},
    {4'd4, 16'h0280, 16'h0280, 1'b1, 2'd0},
    {4'd0, 16'h0100, 16'h0100, 1'b0, 2'd1},
    {4'd8, 16'hFFFF, 16'h3FFF, 1'b0, 2'd3},
    {4'd6, 16'h0003, 16'h0003, 1'b1, 2'd0},
    {4'd3, 16'h0020, 16'h0020, 1'b0, 2'd1},
    {4'd7, 16'h0002, 16'h0002, 1'b1, 2'd0},
    {4'd5, 16'h0004, 16'h0004, 1'b1, 2'd0}
  };

  function automatic string kind_tag(logic [1:0] k);
    case (k)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NS*DW-1:0] model_bus();
    logic [NS*DW-1:0] b;
    for (int i = 0; i < NS; i++) b[i*DW +: DW] = m_act[i];
    return b;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl(input bit h, input bit s, input bit r);
    g_hold = h; g_show = s; g_rst = r;
    wr(4'd9, {13'd0, r, s, h});
  endtask

  task automatic run_frame(input bit exp_bad, input string tag);
    int fvc, lvc, rsc;
    fvc = 0; lvc = 0; rsc = 0;
    @(negedge clk);
    check(act_bus == model_bus(), {tag, " R2 pre-boundary"}, 64'(act_bus), 64'(model_bus()));
    frame_start = 1'b1;
    if (!g_hold) for (int i = 0; i < NS; i++) m_act[i] = m_pend[i];
    @(negedge clk);
    frame_start = 1'b0;
    rsc += int'(restart_req);
    check(act_bus == model_bus(), {tag, " R2 post-boundary"}, 64'(act_bus), 64'(model_bus()));
    for (int k = 0; k < 12; k++) begin
      fv_in = 1'b1; lv_in = (k % 4) != 0;
      @(negedge clk);
      fvc += int'(fv_out); lvc += int'(lv_out); rsc += int'(restart_req);
    end
    fv_in = 1'b0; lv_in = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      fvc += int'(fv_out); lvc += int'(lv_out); rsc += int'(restart_req);
    end
    check(fvc == ((exp_bad && !g_show) ? 0 : 12), {tag, " R7/R8 fv count"}, 64'(fvc), 64'((exp_bad && !g_show) ? 0 : 12));
    check(lvc == ((exp_bad && !g_show) ? 0 : 9),  {tag, " R7/R8 lv count"}, 64'(lvc), 64'((exp_bad && !g_show) ? 0 : 9));
    check(rsc == ((exp_bad && g_rst) ? 1 : 0),    {tag, " R9 restart pulses"}, 64'(rsc), 64'((exp_bad && g_rst) ? 1 : 0));
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    frame_start = 1'b0; fv_in = 1'b0; lv_in = 1'b0;
    g_hold = 0; g_show = 0; g_rst = 0;
    for (int i = 0; i < NS; i++) begin m_pend[i] = '0; m_act[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(act_bus == '0, "R1 active settings", 64'(act_bus), 64'd0);
    check(!fv_out && !lv_out, "R1 valid outputs", {62'd0, fv_out, lv_out}, 64'd0);
    check(!restart_req, "R1 restart", 64'(restart_req), 64'd0);
    // R1: control bits at 0 -> a frame with no change passes, no restart
    run_frame(1'b0, "R1 default frame");

    // table of writes, one frame each, restart enabled, masking on
    set_ctrl(1'b0, 1'b0, 1'b1);
    for (int v = 0; v < 10; v++) begin
      logic [AW-1:0] a;
      a = VEC[v][38:35];
      wr(a, VEC[v][34:19]);
      m_pend[a] = VEC[v][18:3];
      run_frame(VEC[v][2], kind_tag(VEC[v][1:0]));
      check(act_bus[a*DW +: DW] == VEC[v][18:3], {kind_tag(VEC[v][1:0]), " active value"},
            64'(act_bus[a*DW +: DW]), 64'(VEC[v][18:3]));
    end

    // R12: next frame without change is good
    run_frame(1'b0, "R12 frame after bad");

    // R3: hold freezes transfer, release applies all pending
    set_ctrl(1'b1, 1'b0, 1'b1);
    wr(4'd2, 16'h0044); m_pend[2] = 16'h0044;
    wr(4'd1, 16'h0055); m_pend[1] = 16'h0055;
    run_frame(1'b0, "R3 held frame");
    check(act_bus[2*DW +: DW] == 16'h0010, "R3 held hblank", 64'(act_bus[2*DW +: DW]), 64'h10);
    run_frame(1'b0, "R3 second held frame");
    set_ctrl(1'b0, 1'b0, 1'b1);
    run_frame(1'b1, "R3 release frame");
    check(act_bus[1*DW +: DW] == 16'h0055, "R3 gain after release", 64'(act_bus[1*DW +: DW]), 64'h55);

    // R8: show-bad passes the bad frame; restart off -> no pulse (R9)
    set_ctrl(1'b0, 1'b1, 1'b0);
    wr(4'd4, 16'h0140); m_pend[4] = 16'h0140;
    run_frame(1'b1, "R8 shown bad frame");

    // R9: restart on with show-bad -> pulse but frame passes
    set_ctrl(1'b0, 1'b1, 1'b1);
    wr(4'd6, 16'h0001); m_pend[6] = 16'h0001;
    run_frame(1'b1, "R9 restart with show");

    // R11: unmapped address changes nothing (bad frame would expose a geometry hit)
    set_ctrl(1'b0, 1'b0, 1'b1);
    wr(4'd12, 16'hABCD);
    wr(4'd15, 16'h0001);
    run_frame(1'b0, "R11 unmapped write");
    // R11: control bits intact: a geometry change is still masked
    wr(4'd7, 16'h0009); m_pend[7] = 16'h0009;
    run_frame(1'b1, "R11 ctrl intact");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule